// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Timer Bank

This block is a bank of PWM timer channels that share one control word. Each channel has a down-counter and a compare register, and both are fed from a pair of software-written buffers. The buffers reach the active registers at two moments only. The first is while the channel's manual-update bit is held. The second is on a tick that finds the counter at zero with auto-reload enabled; that reload also raises a one-cycle interrupt.

Software sets the period by writing the count buffer. It sets the duty by writing the compare buffer with the period count minus the duty count, so the output is active once the counter has fallen to the compare value. A new pair is committed by writing the control word with manual update set, then writing it again with manual update cleared. Each channel advances only on cycles where its tick input is high. A channel's four control bits are start (offset 0), manual update (offset 1), output invert (offset 2) and auto-reload (offset 3). Channel 0 uses bits 0 to 3 of the control word. Channel n, for n of 1 or more, uses bits 4n+4 to 4n+7. Bits 4 to 7 belong to no channel.

Top module: `pwm_bank`

## Requirements
- R1: After reset, the control word and all buffers, counts and compare values are zero, irq is all zero, and every pwm_out is 1 (a count of 0 is at or below a compare of 0).
- R2: Control bits for channel 0 sit at bits 0..3 and for channel n≥1 at bits 4n+4..4n+7, each as start/manual/invert/reload at offsets 0/1/2/3; bits 4..7, and any bit above the last channel, read as 0 and writes to them are ignored.
- R3: Register map: address 0 is the control word; address 1+2n writes channel n's count buffer and reads channel n's live count; address 2+2n writes and reads channel n's compare buffer; reads of unmapped addresses return 0.
- R4: While a channel's manual bit is set, the count and compare buffers are copied into the active registers on every clock, and ticks do not decrement the count.
- R5: With start set and manual clear, each clock with the channel's tick high lowers a non-zero count by exactly one.
- R6: With start clear, the count holds through ticks, and the output holds its level.
- R7: pwm_out is 1 when the count is at or below the compare value and 0 when it is above, inverted when the invert bit is set.
- R8: A tick that finds the count at zero with start and reload set loads both buffers, and irq for that channel is high for exactly the following cycle.
- R9: A tick that finds the count at zero with reload clear leaves the count at zero and raises no irq.
- R10: Writing a buffer while a channel runs does not change its active count until the next manual update or reload.
- R11: Ticks and control bits of one channel do not affect any other channel's count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | NCH | Per-channel count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read data, combinational |
| pwm_out | output | NCH | PWM output level per channel |
| irq | output | NCH | One-cycle interrupt per channel on reload |

## Verification
The hardest condition to create is a commit of new buffer values into a channel while it runs. The manual bit has to be high for at least one clock edge and then drop in a second control write, and only the two-write sequence proves that the copy happens. The stimulus does exactly that: one write sets manual, the next write clears it and sets start, and a tick burst follows. The live count read through the count address then shows the committed value minus the number of ticks. For the reload path, ticks keep running past zero, so the reload and its single irq cycle are seen in the cycle right after the zero-count tick.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

   // per-channel control nibble; packed so start lands at offset 0
   typedef struct packed {
      logic reload;
      logic invert;
      logic manual;
      logic start;
   } chan_ctl_t;

   localparam int CTL_BITS = 4;

   // bit position of a channel's control nibble in the shared word
   function automatic int ctl_base(input int n);
      return (n == 0) ? 0 : (4 * n + 4);
   endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
   import pwm_bank_pkg::*;
#(
   parameter int NCH  = 5,
   parameter int CW   = 16,
   parameter int DW   = 32,
   parameter int AW   = 4,
   parameter int CTLW = 24
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [AW-1:0]            wr_addr,
   input  logic [DW-1:0]            wr_data,
   input  logic [AW-1:0]            rd_addr,
   output logic [DW-1:0]            rd_data,
   input  logic [NCH-1:0][CW-1:0]   live_cnt,
   output logic [CTLW-1:0]          ctl_word,
   output logic [NCH-1:0][CW-1:0]   cnt_buf,
   output logic [NCH-1:0][CW-1:0]   cmp_buf
);

   logic [CTLW-1:0] ctl_mask;

   always_comb begin
      ctl_mask = '0;
      for (int n = 0; n < NCH; n++)
         ctl_mask[ctl_base(n) +: CTL_BITS] = '1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl_word <= '0;
      else if (wr_en && wr_addr == '0)
         ctl_word <= wr_data[CTLW-1:0] & ctl_mask;
   end

   for (genvar g = 0; g < NCH; g++) begin : g_buf
      localparam logic [AW-1:0] CNT_A = AW'(1 + 2 * g);
      localparam logic [AW-1:0] CMP_A = AW'(2 + 2 * g);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_buf[g] <= '0;
            cmp_buf[g] <= '0;
         end else if (wr_en) begin
            if (wr_addr == CNT_A) cnt_buf[g] <= wr_data[CW-1:0];
            if (wr_addr == CMP_A) cmp_buf[g] <= wr_data[CW-1:0];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == '0)
         rd_data = DW'(ctl_word);
      for (int n = 0; n < NCH; n++) begin
         if (rd_addr == AW'(1 + 2 * n)) rd_data = DW'(live_cnt[n]);
         if (rd_addr == AW'(2 + 2 * n)) rd_data = DW'(cmp_buf[n]);
      end
   end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
   import pwm_bank_pkg::*;
#(
   parameter int CW      = 16,
   parameter bit REG_OUT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  chan_ctl_t     ctl,
   input  logic [CW-1:0] cnt_buf,
   input  logic [CW-1:0] cmp_buf,
   output logic [CW-1:0] cnt,
   output logic          level,
   output logic          irq
);

   logic [CW-1:0] cmp;
   logic          run_tick;
   logic          at_zero;
   logic          raw_level;

   assign run_tick = ctl.start && tick && !ctl.manual;
   assign at_zero  = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         cmp <= '0;
         irq <= 1'b0;
      end else begin
         irq <= run_tick && at_zero && ctl.reload;
         if (ctl.manual) begin
            cnt <= cnt_buf;
            cmp <= cmp_buf;
         end else if (run_tick) begin
            if (!at_zero) begin
               cnt <= cnt - 1'b1;
            end else if (ctl.reload) begin
               cnt <= cnt_buf;
               cmp <= cmp_buf;
            end
         end
      end
   end

   assign raw_level = (cnt <= cmp) ^ ctl.invert;

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) level <= 1'b1;
         else        level <= raw_level;
      end
   end else begin : g_comb_out
      assign level = raw_level;
   end

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int NCH     = 5,
   parameter int CW      = 16,
   parameter int DW      = 32,
   parameter bit REG_OUT = 1'b0,
   localparam int AW     = $clog2(2 * NCH + 1),
   localparam int CTLW   = 4 * NCH + 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] tick,
   input  logic           wr_en,
   input  logic [AW-1:0]  wr_addr,
   input  logic [DW-1:0]  wr_data,
   input  logic [AW-1:0]  rd_addr,
   output logic [DW-1:0]  rd_data,
   output logic [NCH-1:0] pwm_out,
   output logic [NCH-1:0] irq
);

   initial begin
      assert (NCH >= 2) else $error("NCH must be at least 2");
      assert (CTLW <= DW) else $error("control word wider than bus");
      assert (CW <= DW && CW >= 2) else $error("bad counter width");
   end

   logic [CTLW-1:0]          ctl_word;
   logic [NCH-1:0][CW-1:0]   cnt_buf;
   logic [NCH-1:0][CW-1:0]   cmp_buf;
   logic [NCH-1:0][CW-1:0]   cnt_all;
   chan_ctl_t [NCH-1:0]      ctl_all;

   pwm_regs #(.NCH(NCH), .CW(CW), .DW(DW), .AW(AW), .CTLW(CTLW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .live_cnt (cnt_all),
      .ctl_word (ctl_word),
      .cnt_buf  (cnt_buf),
      .cmp_buf  (cmp_buf)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      assign ctl_all[g] = chan_ctl_t'(ctl_word[ctl_base(g) +: CTL_BITS]);
      pwm_chan #(.CW(CW), .REG_OUT(REG_OUT)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (tick[g]),
         .ctl     (ctl_all[g]),
         .cnt_buf (cnt_buf[g]),
         .cmp_buf (cmp_buf[g]),
         .cnt     (cnt_all[g]),
         .level   (pwm_out[g]),
         .irq     (irq[g])
      );
   end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
   import pwm_bank_pkg::*;
#(
   parameter int NCH = 5,
   parameter int CW  = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NCH-1:0]         tick,
   input logic [NCH-1:0]         irq,
   input logic [NCH-1:0][CW-1:0] cnt_all,
   input logic [NCH-1:0][CW-1:0] cnt_buf,
   input chan_ctl_t [NCH-1:0]    ctl_all
);

   for (genvar g = 0; g < NCH; g++) begin : g_chk
      AST_MANUAL_COPY: assert property (@(posedge clk) disable iff (!rst_n)
         ctl_all[g].manual |=> cnt_all[g] == $past(cnt_buf[g])); // R4

      AST_DOWN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
         (ctl_all[g].start && tick[g] && !ctl_all[g].manual && cnt_all[g] != '0)
         |=> cnt_all[g] == $past(cnt_all[g]) - 1'b1); // R5

      AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
         (!ctl_all[g].start && !ctl_all[g].manual) |=> $stable(cnt_all[g])); // R6

      AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
         (ctl_all[g].start && tick[g] && !ctl_all[g].manual && cnt_all[g] == '0 && ctl_all[g].reload)
         |=> irq[g] && cnt_all[g] == $past(cnt_buf[g])); // R8

      AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
         (ctl_all[g].start && tick[g] && !ctl_all[g].manual && cnt_all[g] == '0 && !ctl_all[g].reload)
         |=> cnt_all[g] == '0 && !irq[g]); // R9

      AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq[g]) |-> $past(tick[g])); // R8
   end

endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .CW(CW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .irq     (irq),
   .cnt_all (cnt_all),
   .cnt_buf (cnt_buf),
   .ctl_all (ctl_all)
);

// File: tb/sim_pwm_bank.sv
`timescale 1ns/1ps
module sim_pwm_bank;
   localparam int NCH = 5;
   localparam int CW  = 16;
   localparam int DW  = 32;
   localparam int AW  = $clog2(2 * NCH + 1);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] tick = '0;
   logic           wr_en = 1'b0;
   logic [AW-1:0]  wr_addr = '0;
   logic [DW-1:0]  wr_data = '0;
   logic [AW-1:0]  rd_addr = '0;
   logic [DW-1:0]  rd_data;
   logic [NCH-1:0] pwm_out;
   logic [NCH-1:0] irq;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   pwm_bank #(.NCH(NCH), .CW(CW), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .pwm_out(pwm_out), .irq(irq)
   );

   typedef struct packed {
      logic [3:0]  ch;
      logic [15:0] cb;
      logic [15:0] pb;
      logic [7:0]  nt;
      logic [15:0] ec;
      logic        eo;
   } vec_t;

   // one-shot runs: committed buffers, N ticks, expected count and level
   localparam vec_t TBL [6] = '{
      '{4'd0, 16'd10,  16'd4,   8'd3, 16'd7,   1'b0},  // R5
      '{4'd1, 16'd10,  16'd4,   8'd6, 16'd4,   1'b1},  // R5 R7
      '{4'd2, 16'd5,   16'd0,   8'd5, 16'd0,   1'b1},  // R5
      '{4'd3, 16'd5,   16'd0,   8'd9, 16'd0,   1'b1},  // R9
      '{4'd4, 16'd200, 16'd199, 8'd1, 16'd199, 1'b1},  // R7
      '{4'd0, 16'h100, 16'h80,  8'd0, 16'h100, 1'b0}   // R4
   };

   function automatic int base_of(input int n);
      return (n == 0) ? 0 : 4 * n + 4;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      rd_addr = AW'(a);
      #1;
      d = rd_data;
   endtask

   task automatic ticks(input int ch, input int n);
      if (n > 0) begin
         tick = NCH'(1) << ch;
         repeat (n) @(negedge clk);
         tick = '0;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(0, v); chk("R1 ctl", v, 0);
      rd(1, v); chk("R1 count0", v, 0);
      rd(10, v); chk("R1 cmp4", v, 0);
      chk("R1 irq", 32'(irq), 0);
      chk("R1 pwm_out", 32'(pwm_out), 32'h1F);

      // R2 unused bits and layout
      wr(0, 32'hFF0000F0);
      rd(0, v); chk("R2 gap bits ignored", v, 0);
      wr(0, 32'h0000_0400);
      rd(0, v); chk("R2 ch1 invert at bit 10", v, 32'h400);
      chk("R2 ch1 inverted level", 32'(pwm_out[1]), 0);
      wr(0, 0);

      // table walk
      foreach (TBL[i]) begin
         automatic int ch = int'(TBL[i].ch);
         automatic int b  = base_of(ch);
         wr(1 + 2 * ch, 32'(TBL[i].cb));
         wr(2 + 2 * ch, 32'(TBL[i].pb));
         wr(0, 32'h2 << b);
         wr(0, 32'h1 << b);
         ticks(ch, int'(TBL[i].nt));
         rd(1 + 2 * ch, v); chk("R5/R9 table count", v, 32'(TBL[i].ec));
         chk("R7 table level", 32'(pwm_out[ch]), 32'(TBL[i].eo));
         chk("R9 table no irq", 32'(irq), 0);
      end
      wr(0, 0);

      // R3 readback and unmapped address
      rd(4, v); chk("R3 cmp buffer ch1", v, 4);
      rd(15, v); chk("R3 unmapped", v, 0);

      // R4 manual held: ticks do not count
      wr(9, 77);
      wr(0, 32'h2 << 20);
      ticks(4, 3);
      rd(9, v); chk("R4 manual holds buffer", v, 77);
      wr(0, 0);

      // R5 R10 R6 R7 R11 on channel 1
      wr(3, 20); wr(4, 10);
      wr(0, 32'h2 << 8);
      wr(0, 32'h1 << 8);
      ticks(1, 3);
      rd(3, v); chk("R5 count 20-3", v, 17);
      wr(3, 50);
      rd(3, v); chk("R10 buffer write leaves count", v, 17);
      ticks(1, 2);
      rd(3, v); chk("R10 counts from old value", v, 15);
      rd(9, v); chk("R11 ch4 untouched", v, 77);
      wr(0, 0);
      ticks(1, 5);
      rd(3, v); chk("R6 frozen count", v, 15);
      chk("R6 level held", 32'(pwm_out[1]), 0);
      wr(0, 32'h4 << 8);
      chk("R7 invert", 32'(pwm_out[1]), 1);
      wr(0, 0);

      // R8 auto-reload on channel 0
      wr(1, 3); wr(2, 1);
      wr(0, 32'hA);
      wr(0, 32'h9);
      tick = 5'b00001;
      repeat (3) @(negedge clk);
      rd(1, v); chk("R8 reached zero", v, 0);
      chk("R8 no irq yet", 32'(irq), 0);
      @(negedge clk);
      tick = '0;
      rd(1, v); chk("R8 reloaded", v, 3);
      chk("R8 irq pulse", 32'(irq), 1);
      chk("R7 level above cmp", 32'(pwm_out[0]), 0);
      @(negedge clk);
      chk("R8 irq one cycle", 32'(irq), 0);
      rd(9, v); chk("R11 ch4 still", v, 77);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule